// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Interface Model

This block is a synthesizable digital model of the device side of a four-wire serial sampling converter running in external-clock mode. A host lowers the active-low select, toggles the serial clock and shifts in an 8-bit command that opens with a start bit. The command picks the input channel, chooses single-ended or differential input and sets the power and clock mode. The model then captures a 16-bit digital stand-in for the analog input and runs one successive-approximation decision per serial clock. It returns the code MSB first, one bit on each falling serial edge.

All logic runs on a fast system clock. The serial clock and select are sampled against it, and rising and falling serial edges are found by comparing the current level with the level one system cycle earlier. The serial data output and the busy flag each come with an output-enable, so a pad ring can tri-state them. Outputs that show the multiplexer setting, the acquisition window, the power state and the clock-mode bit stand in for the analog side.

Top module: `sar_serial_adc`

## Requirements
- R1: `sdi` is taken only on a rising `sclk` edge while `cs_n` is low. Zeros before the first 1 are ignored, and that first 1 is the start bit that opens a command.
- R2: The seven bits after the start bit are, in this order: channel code bit 2, bit 1 and bit 0; one bit that is ignored; the input-mode bit (1 = single-ended, 0 = differential); power bit 1; power bit 0. `mux_sel` takes the channel code on the rising edge of channel bit 0, and `mux_single` takes the input-mode bit on its own rising edge.
- R3: `acquiring` rises on the rising edge that delivers channel bit 0, which is command bit 4. It falls on the rising edge of command bit 8, the hold point. At that point `sample_in` is captured, and later changes to `sample_in` do not alter the result.
- R4: `busy` goes high on the falling edge after command bit 8 and stays high for exactly one serial clock period.
- R5: On the 16 falling edges after the busy period, `sdo` carries the result MSB first. The result is straight binary and equals the captured sample: 0 for zero input, all ones for full scale minus one LSB.
- R6: `sdi` is ignored during the 16 decision clocks. After the LSB, `sdo` shifts zeros. A start bit on the very next rising edge after the LSB decision is accepted, so back-to-back conversions take 24 clocks each.
- R7: While `cs_n` is high, `sdo_oe` and `busy_oe` are low and any command or conversion in progress is dropped. After `cs_n` falls, `busy` and `sdo` are driven low.
- R8: Power code {bit1,bit0}: 00 powers down between conversions and keeps the clock mode; 10 stays powered and sets `clk_internal`; 11 stays powered and clears `clk_internal`; 01 is reserved and changes nothing.
- R9: The power code of a command takes effect only when that conversion's last decision is made. A conversion dropped by `cs_n` or shutdown never applies its code.
- R10: `powered_up` is high from acquisition through the last decision. Between conversions it stays high only when the active power code keeps the part powered.
- R11: While `shdn_n` is low, `powered_up` is low and any conversion is abandoned, with `busy`, `sdo` and `acquiring` low. The power and clock mode survive the shutdown.
- R12: After reset, `sdo`, `busy`, `acquiring`, `powered_up`, `clk_internal` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low forced shutdown |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command input |
| sample_in | input | DATA_W | Digital stand-in for the analog input |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for `sdo` |
| busy | output | 1 | Busy flag |
| busy_oe | output | 1 | Output enable for `busy` |
| mux_sel | output | 3 | Selected channel code |
| mux_single | output | 1 | 1 = single-ended, 0 = differential |
| acquiring | output | 1 | Sampling window is open |
| powered_up | output | 1 | Converter core powered |
| clk_internal | output | 1 | Clock-mode bit, 1 = internal clock selected |

## Verification
The bound checker watches several properties on every cycle. Busy lasts a single serial period. `sdo` moves only on a falling serial edge. The acquisition window is open at the hold point and closes right after it. Raising the select or asserting shutdown clears `busy`, `sdo` and acquisition. The clock-mode bit changes only right after a conversion's last decision. Only the bench scenarios can show the rest. That covers the command-bit order and the input-mode bit, captured-sample results across an exhaustive sweep of command bytes, leading-zero and back-to-back 24-clock framing, and the effect of every power code. It also covers dropped conversions leaving the mode unchanged, and the power state on either side of a shutdown.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CTRL = 2'd1,
    PH_CONV = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    PM_AUTO_OFF = 2'b00,
    PM_RSVD     = 2'b01,
    PM_INT_CLK  = 2'b10,
    PM_EXT_ON   = 2'b11
  } pmode_t;

  // next {keep_on, clk_int} after a conversion completes with code pm
  function automatic logic [1:0] pm_next(input pmode_t pm, input logic keep, input logic intc);
    case (pm)
      PM_AUTO_OFF: pm_next = {1'b0, intc};
      PM_INT_CLK:  pm_next = 2'b11;
      PM_EXT_ON:   pm_next = 2'b10;
      default:     pm_next = {keep, intc};
    endcase
  endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = ~cs_n & sclk & ~sclk_q;
  assign fall = ~cs_n & ~sclk & sclk_q;
endmodule

// File: rtl/sar_ctrl_frame.sv
module sar_ctrl_frame
  import sar_if_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SW = $clog2(DATA_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          rise,
  input  logic          sdi,
  output logic          ev_hold,
  output logic          ev_step,
  output logic          ev_last,
  output logic [SW-1:0] step_idx,
  output logic [2:0]    chan,
  output logic          single,
  output pmode_t        pm,
  output logic          acq,
  output logic          conv
);
  localparam logic [SW-1:0] LAST_STEP = SW'(DATA_W - 1);

  phase_t        phase;
  logic [2:0]    cbit;
  logic [1:0]    sr;
  logic [SW-1:0] step;

  assign ev_hold  = rise & ~abort & (phase == PH_CTRL) & (cbit == 3'd6);
  assign ev_step  = rise & ~abort & (phase == PH_CONV);
  assign ev_last  = ev_step & (step == LAST_STEP);
  assign step_idx = step;
  assign conv     = (phase == PH_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cbit   <= '0;
      sr     <= '0;
      step   <= '0;
      chan   <= '0;
      single <= 1'b0;
      pm     <= PM_AUTO_OFF;
      acq    <= 1'b0;
    end else if (abort) begin
      phase <= PH_IDLE;
      cbit  <= '0;
      step  <= '0;
      acq   <= 1'b0;
    end else if (rise) begin
      case (phase)
        PH_IDLE: if (sdi) begin
          phase <= PH_CTRL;
          cbit  <= '0;
        end
        PH_CTRL: begin
          sr   <= {sr[0], sdi};
          cbit <= cbit + 3'd1;
          if (cbit == 3'd2) begin
            chan <= {sr, sdi};
            acq  <= 1'b1;
          end
          if (cbit == 3'd4) single <= sdi;
          if (cbit == 3'd6) begin
            pm    <= pmode_t'({sr[0], sdi});
            phase <= PH_CONV;
            acq   <= 1'b0;
            step  <= '0;
          end
        end
        PH_CONV: begin
          step <= step + SW'(1);
          if (step == LAST_STEP) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DATA_W = 16,
  localparam int SW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hold,
  input  logic              ev_step,
  input  logic [SW-1:0]     step_idx,
  input  logic [DATA_W-1:0] sample_in,
  output logic              dec
);
  localparam logic [SW-1:0] TOP_POS = SW'(DATA_W - 1);

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] trial;

  // trial code: accumulated bits plus the bit under test
  function automatic logic [DATA_W-1:0] trial_code(input logic [DATA_W-1:0] a, input logic [SW-1:0] s);
    return a | (DATA_W'(1) << (TOP_POS - s));
  endfunction

  // comparator stand-in: keep the bit when the input reaches the trial level
  function automatic logic keep_bit(input logic [DATA_W-1:0] vin, input logic [DATA_W-1:0] t);
    return vin >= t;
  endfunction

  assign trial = trial_code(acc, step_idx);
  assign dec   = keep_bit(held, trial);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      acc  <= '0;
    end else if (ev_hold) begin
      held <= sample_in;
      acc  <= '0;
    end else if (ev_step) begin
      if (dec) acc <= trial;
    end
  end
endmodule

// File: rtl/sar_tx_stage.sv
module sar_tx_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic ev_hold,
  input  logic ev_step,
  input  logic dec,
  input  logic fall,
  output logic sdo,
  output logic busy
);
  logic busy_pend, bit_pend, bit_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_pend <= 1'b0;
      bit_pend  <= 1'b0;
      bit_vld   <= 1'b0;
      sdo       <= 1'b0;
      busy      <= 1'b0;
    end else if (abort) begin
      busy_pend <= 1'b0;
      bit_pend  <= 1'b0;
      bit_vld   <= 1'b0;
      sdo       <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (ev_hold) busy_pend <= 1'b1;
      if (ev_step) begin
        bit_pend <= dec;
        bit_vld  <= 1'b1;
      end
      if (fall) begin
        busy      <= busy_pend;
        busy_pend <= 1'b0;
        sdo       <= bit_vld & bit_pend;
        bit_vld   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_power_mode.sv
module sar_power_mode
  import sar_if_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_last,
  input  pmode_t pm,
  output logic   keep_on,
  output logic   clk_int
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_on <= 1'b0;
      clk_int <= 1'b0;
    end else if (ev_last) begin
      {keep_on, clk_int} <= pm_next(pm, keep_on, clk_int);
    end
  end
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc
  import sar_if_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              busy_oe,
  output logic [2:0]        mux_sel,
  output logic              mux_single,
  output logic              acquiring,
  output logic              powered_up,
  output logic              clk_internal
);
  logic          ev_rise, ev_fall, ev_hold, ev_step, ev_last;
  logic          abort, conv, dec, keep_on;
  logic [SW-1:0] step_idx;
  pmode_t        pm;

  assign abort = cs_n | ~shdn_n;

  sar_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .rise(ev_rise), .fall(ev_fall)
  );

  sar_ctrl_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .abort(abort), .rise(ev_rise), .sdi(sdi),
    .ev_hold(ev_hold), .ev_step(ev_step), .ev_last(ev_last), .step_idx(step_idx),
    .chan(mux_sel), .single(mux_single), .pm(pm), .acq(acquiring), .conv(conv)
  );

  sar_core #(.DATA_W(DATA_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .ev_hold(ev_hold), .ev_step(ev_step),
    .step_idx(step_idx), .sample_in(sample_in), .dec(dec)
  );

  sar_tx_stage u_tx (
    .clk(clk), .rst_n(rst_n), .abort(abort), .ev_hold(ev_hold),
    .ev_step(ev_step), .dec(dec), .fall(ev_fall), .sdo(sdo), .busy(busy)
  );

  sar_power_mode u_pwr (
    .clk(clk), .rst_n(rst_n), .ev_last(ev_last), .pm(pm),
    .keep_on(keep_on), .clk_int(clk_internal)
  );

  assign sdo_oe     = ~cs_n;
  assign busy_oe    = ~cs_n;
  assign powered_up = shdn_n & (keep_on | acquiring | conv);
endmodule

// File: rtl/sar_link_chk.sv
module sar_link_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic shdn_n,
  input logic sdo,
  input logic busy,
  input logic acquiring,
  input logic clk_internal,
  input logic ev_fall,
  input logic ev_hold,
  input logic ev_last
);
  // R4
  busy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_fall) |=> !busy);

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fall && !cs_n && shdn_n) |=> $stable(sdo));

  // R3
  acq_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |-> acquiring);

  // R3
  acq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> !acquiring);

  // R7
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!busy && !sdo && !acquiring));

  // R11
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!busy && !sdo && !acquiring));

  // R9
  mode_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_internal) |-> $past(ev_last));
endmodule

bind sar_serial_adc sar_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .shdn_n(shdn_n), .sdo(sdo),
  .busy(busy), .acquiring(acquiring), .clk_internal(clk_internal),
  .ev_fall(ev_fall), .ev_hold(ev_hold), .ev_last(ev_last)
);

// File: tb/sim_sar_serial_adc.sv
module sim_sar_serial_adc;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, shdn_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic sdo, sdo_oe, busy, busy_oe, mux_single, acquiring, powered_up, clk_internal;
  logic [2:0] mux_sel;

  int total = 0, bad = 0;
  bit finished = 0;
  logic exp_keep = 1'b0, exp_int = 1'b0;

  sar_serial_adc #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .busy_oe(busy_oe),
    .mux_sel(mux_sel), .mux_single(mux_single), .acquiring(acquiring),
    .powered_up(powered_up), .clk_internal(clk_internal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one serial clock period; returns with outputs settled after the falling edge
  task automatic sck(input logic d);
    @(negedge clk); sdi = d; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_gap();
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 sdo_oe off", sdo_oe, 0);
    chk("R7 busy_oe off", busy_oe, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 busy_oe on", busy_oe, 1);
    chk("R7 busy low after select", busy, 0);
    chk("R7 sdo low after select", sdo, 0);
  endtask

  function automatic void model_pm(input logic [1:0] pd);
    case (pd)
      2'b00: exp_keep = 1'b0;
      2'b10: begin exp_keep = 1'b1; exp_int = 1'b1; end
      2'b11: begin exp_keep = 1'b1; exp_int = 1'b0; end
      default: ;
    endcase
  endfunction

  function automatic logic [DW-1:0] pat(input int c);
    case (c)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h0001;
      default: return 16'((c * 40503 + 12345) ^ (c << 11));
    endcase
  endfunction

  task automatic frame(input logic [6:0] cw, input logic [DW-1:0] smp, input int pre, input logic junk);
    logic [7:0] cmd;
    logic [DW-1:0] res;
    cmd = {1'b1, cw};
    res = '0;
    sample_in = smp;
    for (int i = 0; i < pre; i++) sck(1'b0);
    chk("R1 leading zeros ignored", acquiring, 0);
    for (int i = 0; i < 8; i++) begin
      sck(cmd[7-i]);
      if (i == 0) chk("R6 zeros after LSB", sdo, 0);
      if (i == 2) chk("R3 no acquire before A0", acquiring, 0);
      if (i == 3) begin
        chk("R3 acquire after A0", acquiring, 1);
        chk("R2 channel code", mux_sel, cw[6:4]);
        chk("R10 powered while acquiring", powered_up, 1);
      end
      if (i == 5) chk("R2 input mode bit", mux_single, cw[2]);
      if (i == 7) begin
        chk("R4 busy after command", busy, 1);
        chk("R3 hold ends acquire", acquiring, 0);
        sample_in = ~smp;
      end
    end
    for (int k = 0; k < DW; k++) begin
      sck(junk);
      res[DW-1-k] = sdo;
      if (k == 0) begin
        chk("R4 busy one period", busy, 0);
        chk("R10 powered while converting", powered_up, 1);
      end
      if (k == DW - 2) chk("R9 mode not yet applied", clk_internal, exp_int);
    end
    chk("R5 result equals captured sample", res, smp);
    model_pm(cw[1:0]);
    chk("R8 clock mode after conversion", clk_internal, exp_int);
    chk("R10 power between conversions", powered_up, exp_keep);
  endtask

  task automatic partial(input logic [6:0] cw, input int nconv);
    logic [7:0] cmd;
    cmd = {1'b1, cw};
    for (int i = 0; i < 8; i++) sck(cmd[7-i]);
    for (int k = 0; k < nconv; k++) sck(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 sdo reset", sdo, 0);
    chk("R12 busy reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 acquiring reset", acquiring, 0);
    chk("R12 powered reset", powered_up, 0);
    chk("R12 clock mode reset", clk_internal, 0);
    chk("R12 channel reset", mux_sel, 0);
    chk("R7 sdo_oe off at idle", sdo_oe, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);

    // exhaustive sweep over the seven command bits after the start bit
    for (int c = 0; c < 128; c++) begin
      frame(7'(c), pat(c), c % 3, c[0]);
      if (c % 4 == 3) cs_gap();
    end

    // R7 / R9: dropped conversion leaves the mode untouched
    frame(7'b101_0_1_11, 16'h1234, 0, 1'b0);
    partial(7'b011_0_0_10, 4);
    cs_gap();
    chk("R9 dropped conversion keeps clock mode", clk_internal, exp_int);
    chk("R9 dropped conversion keeps power", powered_up, exp_keep);
    frame(7'b011_0_0_10, 16'hBEEF, 1, 1'b1);
    chk("R8 internal clock selected", clk_internal, 1);

    // R11: shutdown mid-conversion, mode survives
    partial(7'b110_1_1_00, 3);
    @(negedge clk); shdn_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 powered off in shutdown", powered_up, 0);
    chk("R11 busy low in shutdown", busy, 0);
    chk("R11 sdo low in shutdown", sdo, 0);
    chk("R11 acquiring low in shutdown", acquiring, 0);
    shdn_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 power mode kept", powered_up, exp_keep);
    chk("R11 clock mode kept", clk_internal, exp_int);
    frame(7'b001_0_1_01, 16'hA5A5, 0, 1'b0);
    chk("R8 reserved code keeps clock mode", clk_internal, 1);
    frame(7'b010_0_1_00, 16'h0F0F, 2, 1'b1);
    chk("R8 auto power-down keeps clock mode", clk_internal, 1);
    chk("R8 auto power-down idles off", powered_up, 0);

    wrap_up();
  end
endmodule